// File: doc/BRIEF.md
# UART Buffer Playback Controller

This block sequences one byte-wide UART transmitter between two playback sources. A pulse on the message button streams every location of a read-only message memory out of the transmitter, one byte after another. A pulse on the replay button drains the bytes held in a byte FIFO back out of the same transmitter. Meanwhile, every byte that the UART receiver delivers is pushed into that FIFO, whatever the transmit side is doing.

The transmit side obeys the transmitter's busy flag. A start strobe is only issued while busy is low. After each start, the controller waits for busy to rise and then fall before it fetches the next byte. The message memory and the FIFO both have one cycle of read latency. Once a playback has started, button pulses are ignored until it has finished. The receiver and transmitter status flags are passed straight through to LED outputs.

The controller is a finite-state machine with these states:

- `ST_IDLE`: waiting for a request.
- `ST_ROM_FETCH`: the memory address is presented.
- `ST_FIFO_POP`: a FIFO read is issued.
- `ST_LAUNCH`: the start strobe is issued with the fetched byte.
- `ST_ACK`: waiting for busy to rise.
- `ST_DRAIN`: waiting for busy to fall.

Its transitions are:

- `ST_IDLE` goes to `ST_ROM_FETCH` on a message request.
- `ST_IDLE` goes to `ST_FIFO_POP` on a replay request.
- `ST_ROM_FETCH` and `ST_FIFO_POP` each go to `ST_LAUNCH`.
- `ST_LAUNCH` goes to `ST_ACK` when busy is low.
- `ST_ACK` goes to `ST_DRAIN` when busy is high.
- `ST_DRAIN`, once busy has fallen, goes to one of three states:
  - `ST_ROM_FETCH` for the next address.
  - `ST_FIFO_POP` while the FIFO still holds data.
  - `ST_IDLE` after the end address, or once the FIFO is empty.

Top module: `uart_playback_ctrl`

## Requirements
- R1: A message-button pulse in `ST_IDLE` sends memory addresses 0 through `ROM_END`, in ascending order, one start strobe per byte, and then returns to idle. The memory returns data one cycle after the address is presented.
- R2: `tx_start_o` is a single-cycle pulse that is only issued while `tx_busy_i` is low. No second start is issued until busy has been seen high and then low again.
- R3: Button pulses that arrive during a message playback are ignored: no byte is added, repeated or reordered.
- R4: In every cycle where `rx_valid_i` is high and the FIFO is not full, `fifo_wr_o` is high in that same cycle and `fifo_wdata_o` equals `rx_data_i`.
- R5: A replay-button pulse sends the FIFO contents in FIFO order until `fifo_empty_i` is high. `fifo_rd_o` is only asserted while `fifo_empty_i` is low.
- R6: Button pulses that arrive during a FIFO drain are ignored.
- R7: Bytes sent by a drain leave the FIFO. Bytes received after a drain ends are sent only by the next replay request.
- R8: `led_tx_busy_o`, `led_rx_busy_o` and `led_rx_err_o` follow `tx_busy_i`, `rx_busy_i` and `rx_err_i`.
- R9: If both buttons pulse in the same idle cycle, the message playback runs and the replay request is dropped.
- R10: The start strobe for a FIFO byte comes in the cycle after `fifo_rd_o`, carrying the FIFO read data.
- R11: A received byte that arrives while `fifo_full_i` is high is not written. It sets `overflow_o`, which stays high until reset.
- R12: After reset, `tx_start_o`, `fifo_rd_o`, `fifo_wr_o` and `overflow_o` are low and `rom_addr_o` is 0.
- R13: A replay-button pulse while the FIFO is empty sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_rom_i | input | 1 | Debounced message-button pulse |
| btn_fifo_i | input | 1 | Debounced replay-button pulse |
| tx_start_o | output | 1 | Transmitter start strobe |
| tx_data_o | output | DATA_W | Byte to transmit |
| tx_busy_i | input | 1 | Transmitter busy |
| rx_valid_i | input | 1 | Receiver byte valid |
| rx_data_i | input | DATA_W | Received byte |
| rx_busy_i | input | 1 | Receiver busy |
| rx_err_i | input | 1 | Receiver error |
| rom_addr_o | output | ADDR_W | Message memory address |
| rom_data_i | input | DATA_W | Message memory data (one-cycle latency) |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_wdata_o | output | DATA_W | FIFO write data |
| fifo_full_i | input | 1 | FIFO full |
| fifo_rd_o | output | 1 | FIFO read strobe |
| fifo_rdata_i | input | DATA_W | FIFO read data (one-cycle latency) |
| fifo_empty_i | input | 1 | FIFO empty |
| led_tx_busy_o | output | 1 | Transmitter busy LED |
| led_rx_busy_o | output | 1 | Receiver busy LED |
| led_rx_err_o | output | 1 | Receiver error LED |
| overflow_o | output | 1 | Sticky receive overflow flag |

## Verification
The assertions check the cycle-level contracts on every cycle:

- the start strobe is only issued while busy is low, and is one cycle wide;
- FIFO reads only happen while the FIFO is not empty;
- a FIFO read is followed by a start that carries the read data;
- received bytes are written, or dropped and flagged as overflow;
- the overflow flag stays set;
- the memory address stays within range.

Only the bench's scenarios can show the properties that depend on the whole run: the complete, in-order byte stream of a playback; the lockout of buttons pressed mid-playback; priority when both buttons are pressed together; and the fact that bytes received after a drain wait for the next replay.

// File: rtl/pb_pkg.sv
package pb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROM_FETCH,
        ST_FIFO_POP,
        ST_LAUNCH,
        ST_ACK,
        ST_DRAIN
    } pb_state_e;

    typedef enum logic {
        SRC_ROM,
        SRC_FIFO
    } pb_src_e;
endpackage

// File: rtl/pb_rx_capture.sv
module pb_rx_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid_i,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic              fifo_full_i,
    output logic              fifo_wr_o,
    output logic [DATA_W-1:0] fifo_wdata_o,
    output logic              overflow_o
);
    logic ovf_q;

    // Accept a received byte only while the FIFO has room.
    always_comb begin
        fifo_wr_o    = rx_valid_i && !fifo_full_i;
        fifo_wdata_o = rx_data_i;
    end

    // The overflow flag is sticky: only reset clears it.
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else if (rx_valid_i && fifo_full_i) begin
            ovf_q <= 1'b1;
        end
    end

    assign overflow_o = ovf_q;
endmodule

// File: rtl/pb_req_arb.sv
module pb_req_arb (
    input  logic idle_i,
    input  logic btn_rom_i,
    input  logic btn_fifo_i,
    input  logic fifo_empty_i,
    output logic go_rom_o,
    output logic go_fifo_o
);
    // The message button wins a same-cycle tie.
    // An empty FIFO turns a replay request into a no-op.
    always_comb begin
        go_rom_o  = idle_i && btn_rom_i;
        go_fifo_o = idle_i && btn_fifo_i && !btn_rom_i && !fifo_empty_i;
    end
endmodule

// File: rtl/pb_seq_fsm.sv
module pb_seq_fsm
    import pb_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 4,
    parameter int ROM_END = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_rom_i,
    input  logic              go_fifo_i,
    input  logic              tx_busy_i,
    input  logic              fifo_empty_i,
    input  logic [DATA_W-1:0] rom_data_i,
    input  logic [DATA_W-1:0] fifo_rdata_i,
    output logic              idle_o,
    output logic              tx_start_o,
    output logic [DATA_W-1:0] tx_data_o,
    output logic [ADDR_W-1:0] rom_addr_o,
    output logic              fifo_rd_o
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(ROM_END);

    pb_state_e         state_q, state_d;
    pb_src_e           src_q;
    logic [ADDR_W-1:0] addr_q;
    logic              byte_done;

    // The current byte has finished once busy has fallen in ST_DRAIN.
    assign byte_done = (state_q == ST_DRAIN) && !tx_busy_i;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_rom_i) begin
                    state_d = ST_ROM_FETCH;
                end else if (go_fifo_i) begin
                    state_d = ST_FIFO_POP;
                end
            end
            ST_ROM_FETCH: state_d = ST_LAUNCH;
            ST_FIFO_POP:  state_d = ST_LAUNCH;
            ST_LAUNCH: begin
                if (!tx_busy_i) begin
                    state_d = ST_ACK;
                end
            end
            ST_ACK: begin
                if (tx_busy_i) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (!tx_busy_i) begin
                    if (src_q == SRC_ROM) begin
                        state_d = (addr_q == LAST_ADDR) ? ST_IDLE : ST_ROM_FETCH;
                    end else begin
                        state_d = fifo_empty_i ? ST_IDLE : ST_FIFO_POP;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register, playback source and memory address.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            src_q   <= SRC_ROM;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && go_rom_i) begin
                src_q  <= SRC_ROM;
                addr_q <= '0;
            end else if (state_q == ST_IDLE && go_fifo_i) begin
                src_q <= SRC_FIFO;
            end else if (byte_done && src_q == SRC_ROM && addr_q != LAST_ADDR) begin
                addr_q <= addr_q + 1'b1;
            end
        end
    end

    // Outputs decoded from the current state.
    always_comb begin
        idle_o     = (state_q == ST_IDLE);
        tx_start_o = (state_q == ST_LAUNCH) && !tx_busy_i;
        fifo_rd_o  = (state_q == ST_FIFO_POP) && !fifo_empty_i;
        tx_data_o  = (src_q == SRC_ROM) ? rom_data_i : fifo_rdata_i;
        rom_addr_o = addr_q;
    end
endmodule

// File: rtl/uart_playback_ctrl.sv
module uart_playback_ctrl #(
    parameter int DATA_W    = 8,
    parameter int ROM_DEPTH = 16,
    parameter int ROM_END   = ROM_DEPTH - 1,
    localparam int ADDR_W   = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              btn_rom_i,
    input  logic              btn_fifo_i,
    output logic              tx_start_o,
    output logic [DATA_W-1:0] tx_data_o,
    input  logic              tx_busy_i,
    input  logic              rx_valid_i,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic              rx_busy_i,
    input  logic              rx_err_i,
    output logic [ADDR_W-1:0] rom_addr_o,
    input  logic [DATA_W-1:0] rom_data_i,
    output logic              fifo_wr_o,
    output logic [DATA_W-1:0] fifo_wdata_o,
    input  logic              fifo_full_i,
    output logic              fifo_rd_o,
    input  logic [DATA_W-1:0] fifo_rdata_i,
    input  logic              fifo_empty_i,
    output logic              led_tx_busy_o,
    output logic              led_rx_busy_o,
    output logic              led_rx_err_o,
    output logic              overflow_o
);
    logic idle;
    logic go_rom;
    logic go_fifo;

    pb_rx_capture #(.DATA_W(DATA_W)) u_rx (
        .clk          (clk),
        .rst          (rst),
        .rx_valid_i   (rx_valid_i),
        .rx_data_i    (rx_data_i),
        .fifo_full_i  (fifo_full_i),
        .fifo_wr_o    (fifo_wr_o),
        .fifo_wdata_o (fifo_wdata_o),
        .overflow_o   (overflow_o)
    );

    pb_req_arb u_arb (
        .idle_i       (idle),
        .btn_rom_i    (btn_rom_i),
        .btn_fifo_i   (btn_fifo_i),
        .fifo_empty_i (fifo_empty_i),
        .go_rom_o     (go_rom),
        .go_fifo_o    (go_fifo)
    );

    pb_seq_fsm #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .ROM_END (ROM_END)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .go_rom_i     (go_rom),
        .go_fifo_i    (go_fifo),
        .tx_busy_i    (tx_busy_i),
        .fifo_empty_i (fifo_empty_i),
        .rom_data_i   (rom_data_i),
        .fifo_rdata_i (fifo_rdata_i),
        .idle_o       (idle),
        .tx_start_o   (tx_start_o),
        .tx_data_o    (tx_data_o),
        .rom_addr_o   (rom_addr_o),
        .fifo_rd_o    (fifo_rd_o)
    );

    // Status flags are passed straight through to the LEDs.
    assign led_tx_busy_o = tx_busy_i;
    assign led_rx_busy_o = rx_busy_i;
    assign led_rx_err_o  = rx_err_i;
endmodule

// File: rtl/pb_checker.sv
module pb_checker #(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 4,
    parameter int ROM_END = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              tx_start_o,
    input logic [DATA_W-1:0] tx_data_o,
    input logic              tx_busy_i,
    input logic              rx_valid_i,
    input logic [DATA_W-1:0] rx_data_i,
    input logic [ADDR_W-1:0] rom_addr_o,
    input logic              fifo_wr_o,
    input logic [DATA_W-1:0] fifo_wdata_o,
    input logic              fifo_full_i,
    input logic              fifo_rd_o,
    input logic [DATA_W-1:0] fifo_rdata_i,
    input logic              fifo_empty_i,
    input logic              overflow_o
);
    p_addr_range_r1: assert property (@(posedge clk) disable iff (rst)
        rom_addr_o <= ADDR_W'(ROM_END));

    p_start_not_busy_r2: assert property (@(posedge clk) disable iff (rst)
        tx_start_o |-> !tx_busy_i);

    p_start_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        tx_start_o |=> !tx_start_o);

    p_write_rx_r4: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_i && !fifo_full_i) |-> (fifo_wr_o && fifo_wdata_o == rx_data_i));

    p_read_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_o |-> !fifo_empty_i);

    p_read_then_start_r10: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_o |=> (tx_start_o || tx_busy_i));

    p_read_data_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(fifo_rd_o) && tx_start_o) |-> (tx_data_o == fifo_rdata_i));

    p_no_write_full_r11: assert property (@(posedge clk) disable iff (rst)
        fifo_full_i |-> !fifo_wr_o);

    p_ovf_set_r11: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_i && fifo_full_i) |=> overflow_o);

    p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> overflow_o);
endmodule

bind uart_playback_ctrl pb_checker #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .ROM_END (ROM_END)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_start_o   (tx_start_o),
    .tx_data_o    (tx_data_o),
    .tx_busy_i    (tx_busy_i),
    .rx_valid_i   (rx_valid_i),
    .rx_data_i    (rx_data_i),
    .rom_addr_o   (rom_addr_o),
    .fifo_wr_o    (fifo_wr_o),
    .fifo_wdata_o (fifo_wdata_o),
    .fifo_full_i  (fifo_full_i),
    .fifo_rd_o    (fifo_rd_o),
    .fifo_rdata_i (fifo_rdata_i),
    .fifo_empty_i (fifo_empty_i),
    .overflow_o   (overflow_o)
);

// File: tb/tb_uart_playback_ctrl.sv
module tb_uart_playback_ctrl;
    localparam int DW     = 8;
    localparam int RDEPTH = 16;
    localparam int REND   = 11;
    localparam int AW     = 4;
    localparam int FD     = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          btn_rom = 1'b0, btn_fifo = 1'b0;
    logic          tx_start;
    logic [DW-1:0] tx_data;
    logic          tx_busy;
    logic          rx_valid = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic          rx_busy = 1'b0, rx_err = 1'b0;
    logic [AW-1:0] rom_addr;
    logic [DW-1:0] rom_q = '0;
    logic          fifo_wr, fifo_rd, fifo_full, fifo_empty;
    logic [DW-1:0] fifo_wdata;
    logic [DW-1:0] fifo_rdata = '0;
    logic          led_tx, led_rx, led_err, ovf;

    uart_playback_ctrl #(.DATA_W(DW), .ROM_DEPTH(RDEPTH), .ROM_END(REND)) dut (
        .clk(clk), .rst(rst), .btn_rom_i(btn_rom), .btn_fifo_i(btn_fifo),
        .tx_start_o(tx_start), .tx_data_o(tx_data), .tx_busy_i(tx_busy),
        .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_busy_i(rx_busy), .rx_err_i(rx_err),
        .rom_addr_o(rom_addr), .rom_data_i(rom_q),
        .fifo_wr_o(fifo_wr), .fifo_wdata_o(fifo_wdata), .fifo_full_i(fifo_full),
        .fifo_rd_o(fifo_rd), .fifo_rdata_i(fifo_rdata), .fifo_empty_i(fifo_empty),
        .led_tx_busy_o(led_tx), .led_rx_busy_o(led_rx), .led_rx_err_o(led_err),
        .overflow_o(ovf)
    );

    int total = 0;
    int bad   = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rom_byte(input int a);
        return DW'(a * 7 + 8'h21);
    endfunction

    // Synchronous message memory, one cycle of read latency.
    always @(posedge clk) rom_q <= rom_byte(int'(rom_addr));

    // FIFO model with one cycle of read latency.
    logic [DW-1:0] fmem [FD];
    int            fwp = 0, frp = 0, fcnt = 0;
    assign fifo_full  = (fcnt == FD);
    assign fifo_empty = (fcnt == 0);
    always @(posedge clk) begin
        automatic int c = fcnt;
        if (fifo_wr && fcnt != FD) begin
            fmem[fwp] <= fifo_wdata;
            fwp <= (fwp + 1) % FD;
            c++;
        end
        if (fifo_rd && fcnt != 0) begin
            fifo_rdata <= fmem[frp];
            frp <= (frp + 1) % FD;
            c--;
        end
        fcnt <= c;
    end

    // Transmitter model: busy rises on the edge after a start and holds for a random length.
    int            bcnt = 0;
    logic [DW-1:0] cap [$];
    logic [DW-1:0] expq [$];
    logic          pend_rd = 1'b0;
    logic [DW-1:0] pend_val = '0;
    assign tx_busy = (bcnt != 0);
    always @(posedge clk) begin
        if (!rst) begin
            if (tx_start) begin
                check(!tx_busy, "R2 start while busy", 1, 0);
                cap.push_back(tx_data);
                bcnt <= 3 + int'($urandom_range(0, 7));
            end else if (bcnt != 0) begin
                bcnt <= bcnt - 1;
            end
            if (pend_rd) begin
                check(tx_start && tx_data == pend_val, "R10 start after read",
                      int'(tx_data), int'(pend_val));
            end
            if (fifo_wr && fifo_full) check(1'b0, "R11 write while full", 1, 0);
            pend_rd  <= fifo_rd;
            pend_val <= fmem[frp];
        end
    end

    task automatic rx_byte(input logic [DW-1:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        repeat ($urandom_range(0, 3)) @(negedge clk);
    endtask

    task automatic press(input bit r, input bit f);
        @(negedge clk);
        btn_rom  = r;
        btn_fifo = f;
        @(negedge clk);
        btn_rom  = 1'b0;
        btn_fifo = 1'b0;
    endtask

    task automatic wait_done();
        int quiet = 0;
        while (quiet < 40) begin
            @(negedge clk);
            if (tx_busy || tx_start) quiet = 0;
            else quiet++;
        end
    endtask

    task automatic load_rom_exp();
        expq.delete();
        for (int a = 0; a <= REND; a++) expq.push_back(rom_byte(a));
    endtask

    task automatic compare(input string tag);
        check(cap.size() == expq.size(), {tag, " count"}, cap.size(), expq.size());
        for (int i = 0; i < expq.size() && i < cap.size(); i++) begin
            check(cap[i] == expq[i], {tag, " byte"}, int'(cap[i]), int'(expq[i]));
        end
        cap.delete();
    endtask

    initial begin
        #400000;
        check(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = int'($urandom(32'h5eed));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        check(!tx_start && !fifo_rd && !fifo_wr, "R12 strobes", int'(tx_start), 0);
        check(!ovf, "R12 overflow", int'(ovf), 0);
        check(rom_addr == '0, "R12 address", int'(rom_addr), 0);

        // R8 LED pass-through
        rx_busy = 1'b1; rx_err = 1'b1;
        @(negedge clk);
        check(led_rx && led_err && !led_tx, "R8 leds on", {led_rx, led_err, led_tx}, 3'b110);
        rx_busy = 1'b0; rx_err = 1'b0;
        @(negedge clk);
        check(!led_rx && !led_err, "R8 leds off", {led_rx, led_err}, 0);

        // R13 replay with empty FIFO
        press(1'b0, 1'b1);
        wait_done();
        check(cap.size() == 0, "R13 empty replay", cap.size(), 0);

        // R4 received bytes buffered
        rx_byte("H"); rx_byte("e"); rx_byte("l"); rx_byte("l"); rx_byte("o");
        @(negedge clk);
        check(fcnt == 5, "R4 fifo fill", fcnt, 5);

        // R1 and R3 message playback with presses mid-stream
        press(1'b1, 1'b0);
        repeat (20) @(negedge clk);
        check(led_tx == tx_busy, "R8 tx led", int'(led_tx), int'(tx_busy));
        press(1'b1, 1'b1);
        repeat (33) @(negedge clk);
        press(1'b1, 1'b0);
        wait_done();
        load_rom_exp();
        compare("R1 R3 message");
        check(fcnt == 5, "R3 fifo untouched", fcnt, 5);

        // R5 and R6 drain with presses mid-stream
        press(1'b0, 1'b1);
        repeat (12) @(negedge clk);
        press(1'b0, 1'b1);
        repeat (9) @(negedge clk);
        press(1'b1, 1'b0);
        wait_done();
        expq.delete();
        expq.push_back("H"); expq.push_back("e"); expq.push_back("l");
        expq.push_back("l"); expq.push_back("o");
        compare("R5 R6 drain");
        check(fcnt == 0, "R7 drained empty", fcnt, 0);

        // R7 new bytes only on next replay
        rx_byte("a"); rx_byte("b"); rx_byte("c");
        repeat (60) @(negedge clk);
        check(cap.size() == 0, "R7 no auto send", cap.size(), 0);
        press(1'b0, 1'b1);
        wait_done();
        expq.delete();
        expq.push_back("a"); expq.push_back("b"); expq.push_back("c");
        compare("R7 second drain");

        // R9 simultaneous press: message wins, replay dropped
        rx_byte("x"); rx_byte("y");
        press(1'b1, 1'b1);
        wait_done();
        load_rom_exp();
        compare("R9 message wins");
        check(fcnt == 2, "R9 fifo kept", fcnt, 2);
        press(1'b0, 1'b1);
        wait_done();
        expq.delete();
        expq.push_back("x"); expq.push_back("y");
        compare("R9 later drain");

        // R5 random fills
        for (int k = 0; k < 4; k++) begin
            int n;
            n = int'($urandom_range(1, 6));
            expq.delete();
            for (int j = 0; j < n; j++) begin
                logic [DW-1:0] b;
                b = DW'($urandom);
                expq.push_back(b);
                rx_byte(b);
            end
            press(1'b0, 1'b1);
            wait_done();
            compare("R5 random drain");
        end

        // R11 overflow
        check(!ovf, "R11 clear before", int'(ovf), 0);
        expq.delete();
        for (int j = 0; j < FD; j++) begin
            expq.push_back(DW'(8'h60 + j));
            rx_byte(DW'(8'h60 + j));
        end
        check(!ovf, "R11 clear at full", int'(ovf), 0);
        rx_byte(8'hEE);
        @(negedge clk);
        check(ovf, "R11 overflow set", int'(ovf), 1);
        check(fcnt == FD, "R11 dropped byte", fcnt, FD);
        press(1'b0, 1'b1);
        wait_done();
        compare("R11 drain after overflow");
        check(ovf, "R11 sticky", int'(ovf), 1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!ovf, "R12 overflow cleared", int'(ovf), 0);

        // R1 final full playback
        press(1'b1, 1'b0);
        wait_done();
        load_rom_exp();
        compare("R1 repeat message");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule